// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block models only the lookup side of a set-associative cache. It stores a tag and a valid bit for every way of every set and holds no data. It answers each request with hit or miss. A host drives one address per cycle. The block takes the set index from the middle address bits and the tag from the upper bits, and ignores the offset bits inside the block. It then compares the tag with every way of that set at once.

On a miss the block fills one way of the set. A way that is still empty is used first, and the lowest-numbered empty way wins. Only when every way of the set is valid does the block take the victim way offered by an external replacement selector. The block shows that selector the set index of the current request during the request cycle. One cycle later it gives the selector a hit strobe or a fill strobe, together with the set and way, so the selector can update its own state. Two running counters record the number of lookups and the number of misses.

The geometry is set by parameters: block bytes, ways and total bytes. The number of sets is derived from them. A combination that does not divide evenly, or that gives a block size or set count that is not a power of two, stops elaboration with an error.

Top module: `cache_tag_dir`

## Requirements
- R1: With the default geometry (64-byte blocks, 32 sets, 8 ways, 32-bit address), the set index is address bits [10:6] and the tag is bits [31:11]. Bits [5:0] have no effect on the lookup: two addresses that differ only there find the same entry.
- R2: A request hits only if a way of its set is valid and holds the request's tag. A hit reports `rsp_hit`=1 and `rsp_way` equal to the number of that way, and changes no stored tag.
- R3: A miss in a set that still has an invalid way fills the lowest-numbered invalid way and ignores `vic_way`.
- R4: A miss in a set whose ways are all valid fills the way given on `vic_way`. During the request cycle, `vic_set` shows the request's set index combinationally.
- R5: After a miss, the next access to the same block hits the filled way, even when it comes on the very next cycle. A tag that was replaced misses afterwards.
- R6: A request on `req_valid` in cycle n gives `rsp_valid`=1 with `rsp_set` equal to its set index in cycle n+1. A cycle without a request gives `rsp_valid`=0 in the following cycle.
- R7: Each response carries exactly one update strobe: `upd_hit_stb` when the request hit, `upd_fill_stb` when it missed.
- R8: `acc_count` rises by one for every request and `miss_count` rises by one for every miss. Both counters change in the same cycle as the response.
- R9: Reset clears every valid bit, both counters and `rsp_valid`. The first access to any address after reset misses.
- R10: Sets are independent. A fill in one set never changes the hit or miss result of another set, even for the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request this cycle |
| req_addr | input | ADDR_W | Request address |
| vic_set | output | IDX_W | Set index of the current request, for the replacement selector |
| vic_way | input | WAY_W | Victim way from the replacement selector |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | WAY_W | Way that hit or was filled |
| rsp_set | output | IDX_W | Set index of the response |
| upd_hit_stb | output | 1 | Selector update strobe for a hit |
| upd_fill_stb | output | 1 | Selector update strobe for a fill |
| acc_count | output | CNT_W | Number of lookups since reset |
| miss_count | output | CNT_W | Number of misses since reset |

## Verification
A wrong valid bit or tag stays hidden until the next request to that set. It then appears as a wrong hit/miss result or a wrong way number in the following cycle, so the bench sends requests back to back and fills sets completely, which forces stored state to be read again soon after it is written. A fill choice that ignores empty ways, or that overrides the selector, shows at once as a way number that differs from the reference model. Counter drift shows on the first response after the fault, because the counter values are compared on every response.

// File: rtl/ctdir_pkg.sv
package ctdir_pkg;
  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/ctdir_way.sv
module ctdir_way #(
  parameter int TAG_W = 21,
  parameter int IDX_W = 5,
  parameter int SETS  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             wr_en,
  output logic             hit_o,
  output logic             vld_o
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  vbits;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[set_i] <= tag_i;
  end

  always_ff @(posedge clk) begin
    if (rst) vbits <= '0;
    else if (wr_en) vbits[set_i] <= 1'b1;
  end

  assign vld_o = vbits[set_i];
  assign hit_o = vld_o && (tag_mem[set_i] == tag_i);
endmodule

// File: rtl/ctdir_pick.sv
module ctdir_pick #(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3
) (
  input  logic [WAYS-1:0]  hit_vec,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAY_W-1:0] vic_in,
  output logic             hit,
  output logic [WAY_W-1:0] sel_way,
  output logic [WAYS-1:0]  fill_vec
);
  logic [WAY_W-1:0] hit_way, free_way, victim;
  logic             free_any;

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(i);
      end
    end
    free_any = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_any = 1'b1;
        free_way = WAY_W'(i);
      end
    end
    victim  = (int'(vic_in) < WAYS) ? vic_in : '0;
    sel_way = hit ? hit_way : (free_any ? free_way : victim);
    for (int i = 0; i < WAYS; i++) begin
      fill_vec[i] = !hit && (sel_way == WAY_W'(i));
    end
  end
endmodule

// File: rtl/ctdir_stats.sv
module ctdir_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             miss,
  output logic [CNT_W-1:0] acc,
  output logic [CNT_W-1:0] misses
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      misses <= '0;
    end else if (tick) begin
      acc <= acc + CNT_W'(1);
      if (miss) misses <= misses + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int WAYS        = 8,
  parameter int CACHE_BYTES = 16384,
  parameter int CNT_W       = 32,
  localparam int SETS   = CACHE_BYTES / (BLOCK_BYTES * WAYS),
  localparam int OFF_W  = $clog2(BLOCK_BYTES),
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [IDX_W-1:0]  vic_set,
  input  logic [WAY_W-1:0]  vic_way,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [IDX_W-1:0]  rsp_set,
  output logic              upd_hit_stb,
  output logic              upd_fill_stb,
  output logic [CNT_W-1:0]  acc_count,
  output logic [CNT_W-1:0]  miss_count
);
  import ctdir_pkg::*;

  if (!is_pow2(BLOCK_BYTES) || (CACHE_BYTES % BLOCK_BYTES) != 0 ||
      (CACHE_BYTES % (BLOCK_BYTES * WAYS)) != 0 || SETS < 2 ||
      !is_pow2(SETS) || TAG_W < 1) begin : g_bad_geometry
    $error("cache_tag_dir: illegal geometry parameters");
  end

  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic             offset_unused;
  logic [WAYS-1:0]  hit_vec, valid_vec, fill_vec;
  logic             hit;
  logic [WAY_W-1:0] sel_way;

  assign set_idx       = req_addr[OFF_W +: IDX_W];
  assign req_tag       = req_addr[ADDR_W-1 -: TAG_W];
  assign offset_unused = ^req_addr[OFF_W-1:0];
  assign vic_set       = set_idx;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    ctdir_way #(.TAG_W(TAG_W), .IDX_W(IDX_W), .SETS(SETS)) u_way (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_idx),
      .tag_i (req_tag),
      .wr_en (req_valid && fill_vec[w]),
      .hit_o (hit_vec[w]),
      .vld_o (valid_vec[w])
    );
  end

  ctdir_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .vic_in    (vic_way),
    .hit       (hit),
    .sel_way   (sel_way),
    .fill_vec  (fill_vec)
  );

  ctdir_stats #(.CNT_W(CNT_W)) u_stats (
    .clk    (clk),
    .rst    (rst),
    .tick   (req_valid),
    .miss   (!hit),
    .acc    (acc_count),
    .misses (miss_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_way      <= '0;
      rsp_set      <= '0;
      upd_hit_stb  <= 1'b0;
      upd_fill_stb <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      upd_hit_stb  <= req_valid && hit;
      upd_fill_stb <= req_valid && !hit;
      if (req_valid) begin
        rsp_hit <= hit;
        rsp_way <= sel_way;
        rsp_set <= set_idx;
      end
    end
  end
endmodule

// File: rtl/ctdir_chk.sv
module ctdir_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              upd_hit_stb,
  input logic              upd_fill_stb,
  input logic [CNT_W-1:0]  acc_count,
  input logic [CNT_W-1:0]  miss_count
);
  // R6
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R6
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({upd_hit_stb, upd_fill_stb}) == 1));
  // R7
  miss_means_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> upd_fill_stb);
  // R8
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (acc_count == $past(acc_count) + CNT_W'(1)));
  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(acc_count));
  // R8
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    upd_fill_stb |-> (miss_count == $past(miss_count) + CNT_W'(1)));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_count == '0 && miss_count == '0 && !rsp_valid));
  // R5
  refetch_hits_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(req_valid) && !$past(rst) &&
     req_addr[ADDR_W-1:OFF_W] == $past(req_addr[ADDR_W-1:OFF_W])) |=> rsp_hit);
endmodule

bind cache_tag_dir ctdir_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .upd_hit_stb  (upd_hit_stb),
  .upd_fill_stb (upd_fill_stb),
  .acc_count    (acc_count),
  .miss_count   (miss_count)
);

// File: tb/cache_tag_dir_test.sv
module cache_tag_dir_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 32;
  localparam int NWAYS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [4:0]  vic_set;
  logic [2:0]  vic_way = '0;
  logic        rsp_valid, rsp_hit, upd_hit_stb, upd_fill_stb;
  logic [2:0]  rsp_way;
  logic [4:0]  rsp_set;
  logic [31:0] acc_count, miss_count;

  cache_tag_dir uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .vic_set(vic_set), .vic_way(vic_way), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_set(rsp_set),
    .upd_hit_stb(upd_hit_stb), .upd_fill_stb(upd_fill_stb),
    .acc_count(acc_count), .miss_count(miss_count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    bit    hit;
    int    way;
    int    set;
    int    acc;
    int    miss;
    string req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          mvalid [NSETS][NWAYS];
  logic [20:0] mtag   [NSETS][NWAYS];
  int          e_acc = 0;
  int          e_miss = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int set, input int off);
    return (32'(tag) << 11) | (32'(set) << 6) | 32'(off);
  endfunction

  task automatic model_clear();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) mvalid[s][w] = 1'b0;
    e_acc = 0;
    e_miss = 0;
  endtask

  // driver: computes the expected result from the model and pushes it
  task automatic issue(input logic [31:0] a, input int vic, input string req);
    exp_t e;
    int s, way;
    logic [20:0] t;
    bit h;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    vic_way   = 3'(vic);
    s = int'(a[10:6]);
    t = a[31:11];
    h = 1'b0;
    way = -1;
    for (int w = 0; w < NWAYS; w++)
      if (!h && mvalid[s][w] && mtag[s][w] == t) begin h = 1'b1; way = w; end
    if (!h) begin
      for (int w = 0; w < NWAYS; w++)
        if (way < 0 && !mvalid[s][w]) way = w;
      if (way < 0) way = vic;
      mvalid[s][way] = 1'b1;
      mtag[s][way] = t;
      e_miss++;
    end
    e_acc++;
    e.hit = h; e.way = way; e.set = s; e.acc = e_acc; e.miss = e_miss; e.req = req;
    sb.push_back(e);
    #1;
    chk(vic_set == 5'(s), "R4 vic_set", int'(vic_set), s);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (k > 0) begin
        #2;
        chk(!rsp_valid, "R6 idle rsp_valid", int'(rsp_valid), 0);
      end
    end
  endtask

  // monitor: pops and compares every response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_hit == e.hit, {e.req, " hit"}, int'(rsp_hit), int'(e.hit));
        chk(int'(rsp_way) == e.way, {e.req, " way"}, int'(rsp_way), e.way);
        chk(int'(rsp_set) == e.set, "R6 rsp_set", int'(rsp_set), e.set);
        chk(upd_hit_stb == e.hit && upd_fill_stb == !e.hit, "R7 strobes",
            int'({upd_hit_stb, upd_fill_stb}), e.hit ? 2 : 1);
        chk(int'(acc_count) == e.acc, "R8 acc_count", int'(acc_count), e.acc);
        chk(int'(miss_count) == e.miss, "R8 miss_count", int'(miss_count), e.miss);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk(!rsp_valid, "R9 rsp_valid after reset", int'(rsp_valid), 0);
    chk(acc_count == 0 && miss_count == 0, "R9 counters after reset", int'(acc_count), 0);

    // R9 first access misses, R3 lowest invalid way
    issue(mk(1, 3, 0), 7, "R3");
    // R1 offset ignored, R5 back-to-back refetch hits
    issue(mk(1, 3, 37), 4, "R1");
    // R3 fill the rest of set 3 while vic_way points elsewhere
    for (int t = 2; t <= 8; t++) issue(mk(t, 3, t), 6, "R3");
    // R4 set full: victim way 5 (held tag 6)
    issue(mk(9, 3, 0), 5, "R4");
    // R5 evicted tag 6 misses, goes to victim way 2
    issue(mk(6, 3, 1), 2, "R5");
    issue(mk(9, 3, 63), 0, "R2");
    issue(mk(3, 3, 8), 0, "R5");
    idle(3);
    // R10 same tag in another set misses there, original still hits
    issue(mk(1, 4, 0), 3, "R10");
    issue(mk(1, 3, 0), 3, "R10");
    issue(mk(1, 4, 9), 3, "R10");
    idle(2);

    // mixed traffic with occasional gaps
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      int tg, st;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tg = 1 + int'(lf[3:0]) % 11;
      st = (lf[5:4] == 2'd0) ? 0 : (lf[5:4] == 2'd1) ? 31 : 7;
      issue(mk(tg, st, int'(lf[11:6])), int'(lf[14:12]), "R2");
      if (i % 17 == 16) idle(2);
    end
    idle(3);

    // R9 reset mid-run clears valid bits and counters
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    #1;
    chk(acc_count == 0, "R9 acc cleared", int'(acc_count), 0);
    chk(miss_count == 0, "R9 miss cleared", int'(miss_count), 0);
    issue(mk(9, 3, 0), 1, "R9");
    issue(mk(9, 3, 0), 1, "R5");
    idle(3);

    chk(sb.size() == 0, "R6 missing responses", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule